// File: doc/BRIEF.md
# Command Response Status and Interrupt Unit

This block sits beside a memory-card host's command engine. When a command is issued, it captures the command word together with the response bytes the card returned and the number of bytes that arrived. In the next cycle it judges the response against its type: was it long enough, does the embedded card status carry an error, was the command a stop or an init? It then records the outcome as bits in a 16-bit sticky status register and unpacks the response into eight 16-bit words for software.

Software clears status bits by writing ones and chooses which bits raise the single level interrupt through a 15-bit enable register. A card-detect level input is edge-detected, and each insertion is latched as a status bit. The control is a two-state machine. `S_IDLE` waits for an accepted issue strobe. The `accept` transition goes from `S_IDLE` to `S_EVAL` and captures the command. `S_EVAL` applies the verdict and takes the unconditional `done` transition back to `S_IDLE`. A strobe seen while in `S_EVAL`, or while the controller is disabled, is dropped.

Top module: `cmd_status_unit`

## Requirements
- R1: The command word carries the index in bits 5:0, the init flag in bit 7, the response type in bits 10:8 and busy in bit 11. An issue strobe while `enable_i` is low, or while the unit is in `S_EVAL`, is dropped: neither the status nor the response words change.
- R2: An accepted init command (bit 7 set) with index 0 sets only status bit 0. It loads no response words and leaves bit 14 as it was.
- R3: Response types 1, 3 and 6 need at least 4 bytes, and type 2 needs 16. Types 0, 4, 5 and 7 need none. A shorter `rsp_len_i` sets timeout bit 7 instead of bit 0 and clears bit 14.
- R4: A command with a sufficient response sets bit 0. Index 12 sets bits 0 and 2.
- R5: For type 1, with or without busy, the card status is bytes 0..3 read big-endian (byte 0 most significant), checked against mask 0xFDF90000. For type 6 it is {byte 2, byte 3}, checked against mask 0xE008. Any overlap sets bit 14. Any other evaluated, non-init-zero command clears bit 14.
- R6: Writing the status register (`reg_sel_i`=0) clears each bit written as 1. A set and a clear of the same bit in one cycle leave the bit set.
- R7: Writing the enable register (`reg_sel_i`=1) keeps bits 14:0, and bit 15 reads 0. `irq_o` is registered: it equals the OR of (status AND enable) from the previous cycle.
- R8: A rising edge on `card_det_i` sets status bit 1. A level that stays high does not set it again.
- R9: An accepted issue clears all eight response words. When the response is sufficient and its type is 1, 2, 3 or 6, word k is loaded with {byte 2(7-k), byte 2(7-k)+1}, so word 7 holds bytes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable; issues are dropped while low |
| cmd_go_i | input | 1 | One-cycle command issue strobe |
| cmd_word_i | input | 16 | Command word |
| rsp_bytes_i | input | 128 | Response bytes, byte j at bits 8j+7:8j |
| rsp_len_i | input | 5 | Number of valid response bytes (0 to 16) |
| card_det_i | input | 1 | Card-detect level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects status (write-one-to-clear), 1 selects interrupt enable |
| reg_wdata_i | input | 16 | Register write data |
| irq_o | output | 1 | Level interrupt |
| status_o | output | 16 | Status register |
| ien_o | output | 16 | Interrupt enable readback |
| rsp_words_o | output | 128 | Response words, word k at bits 16k+15:16k |

## Verification
The strobe is captured on the first rising edge. Status bits and response words change on the second edge, and the interrupt follows on the third. A card-detect rise or a register write takes effect on the first edge after it is driven. The bench drives on falling edges and reads on the falling edge after the edge where each result is due. For the interrupt, it also reads one falling edge earlier to confirm that the line has not yet moved. The sweep covers every response type, lengths on both sides of each threshold, indices 0, 5 and 12, both init settings and both error settings.

// File: rtl/csu_pkg.sv
package csu_pkg;

    typedef enum logic [0:0] {
        S_IDLE,
        S_EVAL
    } csu_state_e;

    localparam int BIT_DONE = 0;
    localparam int BIT_CDET = 1;
    localparam int BIT_STOP = 2;
    localparam int BIT_TMO  = 7;
    localparam int BIT_ERR  = 14;

    localparam logic [2:0] RT_SHORT = 3'd1;
    localparam logic [2:0] RT_LONG  = 3'd2;
    localparam logic [2:0] RT_OCR   = 3'd3;
    localparam logic [2:0] RT_RCA   = 3'd6;

    localparam logic [31:0] ERR_MASK_SHORT = 32'hFDF9_0000;
    localparam logic [15:0] ERR_MASK_RCA   = 16'hE008;
    localparam logic [5:0]  IDX_STOP       = 6'd12;

    function automatic int need_bytes(input logic [2:0] rt);
        case (rt)
            RT_SHORT, RT_OCR, RT_RCA: return 4;
            RT_LONG:                  return 16;
            default:                  return 0;
        endcase
    endfunction

endpackage

// File: rtl/csu_rsp_eval.sv
module csu_rsp_eval
    import csu_pkg::*;
#(
    parameter int N_BYTES = 16,
    parameter int LEN_W   = 5,
    parameter int STAT_W  = 16
) (
    input  logic [5:0]           idx_i,
    input  logic                 init_i,
    input  logic [2:0]           rtype_i,
    input  logic [8*N_BYTES-1:0] bytes_i,
    input  logic [LEN_W-1:0]     len_i,
    output logic [STAT_W-1:0]    set_o,
    output logic [STAT_W-1:0]    clr_o,
    output logic                 load_o
);

    logic [31:0] cs_long;
    logic [15:0] cs_short;
    logic        err;
    int          need;

    assign cs_long  = {bytes_i[7:0], bytes_i[15:8], bytes_i[23:16], bytes_i[31:24]};
    assign cs_short = {bytes_i[23:16], bytes_i[31:24]};

    always_comb begin
        need = need_bytes(rtype_i);
        case (rtype_i)
            RT_SHORT: err = |(cs_long & ERR_MASK_SHORT);
            RT_RCA:   err = |(cs_short & ERR_MASK_RCA);
            default:  err = 1'b0;
        endcase

        set_o  = '0;
        clr_o  = '0;
        load_o = 1'b0;
        if (init_i && idx_i == 6'd0) begin
            set_o[BIT_DONE] = 1'b1;
        end else if (int'(len_i) < need) begin
            set_o[BIT_TMO] = 1'b1;
            clr_o[BIT_ERR] = 1'b1;
        end else begin
            set_o[BIT_DONE] = 1'b1;
            set_o[BIT_STOP] = (idx_i == IDX_STOP);
            set_o[BIT_ERR]  = err;
            clr_o[BIT_ERR]  = ~err;
            load_o          = (need != 0);
        end
    end

endmodule

// File: rtl/csu_status.sv
module csu_status
    import csu_pkg::*;
#(
    parameter int STAT_W = 16,
    parameter int IEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_i,
    input  logic [STAT_W-1:0] clr_i,
    input  logic              ien_wr_i,
    input  logic [IEN_W-1:0]  ien_data_i,
    input  logic              card_det_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [IEN_W-1:0]  ien_o,
    output logic              irq_o
);

    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_all;
    logic [STAT_W-1:0] ien_ext;
    logic [IEN_W-1:0]  ien_q;
    logic              cd_prev_q;
    logic              irq_q;

    always_comb begin
        set_all           = set_i;
        set_all[BIT_CDET] = set_i[BIT_CDET] | (card_det_i & ~cd_prev_q);
    end

    assign ien_ext = STAT_W'(ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q    <= '0;
            ien_q     <= '0;
            cd_prev_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            stat_q    <= (stat_q & ~clr_i) | set_all;
            cd_prev_q <= card_det_i;
            irq_q     <= |(stat_q & ien_ext);
            if (ien_wr_i) ien_q <= ien_data_i;
        end
    end

    assign stat_o = stat_q;
    assign ien_o  = ien_q;
    assign irq_o  = irq_q;

    assert_cdet_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (card_det_i && !cd_prev_q) |=> stat_q[BIT_CDET]);

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[BIT_DONE] && !set_all[BIT_DONE]) |=> !stat_q[BIT_DONE]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i[BIT_TMO] && clr_i[BIT_TMO]) |=> stat_q[BIT_TMO]);

    assert_irq_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |($past(stat_q) & $past(ien_ext)));

endmodule

// File: rtl/cmd_status_unit.sv
module cmd_status_unit
    import csu_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int STAT_W  = 16,
    parameter int IEN_W   = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable_i,
    input  logic                   cmd_go_i,
    input  logic [15:0]            cmd_word_i,
    input  logic [16*N_WORDS-1:0]  rsp_bytes_i,
    input  logic [$clog2(2*N_WORDS+1)-1:0] rsp_len_i,
    input  logic                   card_det_i,
    input  logic                   reg_wr_i,
    input  logic                   reg_sel_i,
    input  logic [STAT_W-1:0]      reg_wdata_i,
    output logic                   irq_o,
    output logic [STAT_W-1:0]      status_o,
    output logic [STAT_W-1:0]      ien_o,
    output logic [16*N_WORDS-1:0]  rsp_words_o
);

    localparam int WORD_W  = 16;
    localparam int N_BYTES = 2 * N_WORDS;
    localparam int LEN_W   = $clog2(N_BYTES + 1);
    localparam int VEC_W   = WORD_W * N_WORDS;

    csu_state_e state_q, state_d;

    logic              accept;
    logic [5:0]        idx_q;
    logic              init_q;
    logic [2:0]        rtype_q;
    logic [VEC_W-1:0]  bytes_q;
    logic [LEN_W-1:0]  len_q;
    logic [VEC_W-1:0]  words_q;
    logic [VEC_W-1:0]  mapped;
    logic [STAT_W-1:0] ev_set, ev_clr;
    logic              ev_load;
    logic [STAT_W-1:0] st_set, st_clr;
    logic [IEN_W-1:0]  ien_q;

    assign accept = (state_q == S_IDLE) && cmd_go_i && enable_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_EVAL;
            S_EVAL: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            init_q  <= 1'b0;
            rtype_q <= '0;
            bytes_q <= '0;
            len_q   <= '0;
        end else if (accept) begin
            idx_q   <= cmd_word_i[5:0];
            init_q  <= cmd_word_i[7];
            rtype_q <= cmd_word_i[10:8];
            bytes_q <= rsp_bytes_i;
            len_q   <= rsp_len_i;
        end
    end

    csu_rsp_eval #(.N_BYTES(N_BYTES), .LEN_W(LEN_W), .STAT_W(STAT_W)) u_eval (
        .idx_i  (idx_q),
        .init_i (init_q),
        .rtype_i(rtype_q),
        .bytes_i(bytes_q),
        .len_i  (len_q),
        .set_o  (ev_set),
        .clr_o  (ev_clr),
        .load_o (ev_load)
    );

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        localparam int HI = 2 * (N_WORDS - 1 - k);
        assign mapped[WORD_W*k +: WORD_W] = {bytes_q[8*HI +: 8], bytes_q[8*(HI+1) +: 8]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             words_q <= '0;
        else if (accept)                        words_q <= '0;
        else if (state_q == S_EVAL && ev_load)  words_q <= mapped;
    end

    assign st_set = (state_q == S_EVAL) ? ev_set : '0;
    assign st_clr = ((state_q == S_EVAL) ? ev_clr : '0)
                  | ((reg_wr_i && !reg_sel_i) ? reg_wdata_i : '0);

    csu_status #(.STAT_W(STAT_W), .IEN_W(IEN_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (st_set),
        .clr_i     (st_clr),
        .ien_wr_i  (reg_wr_i && reg_sel_i),
        .ien_data_i(reg_wdata_i[IEN_W-1:0]),
        .card_det_i(card_det_i),
        .stat_o    (status_o),
        .ien_o     (ien_q),
        .irq_o     (irq_o)
    );

    assign ien_o       = STAT_W'(ien_q);
    assign rsp_words_o = words_q;

    assert_drop_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && cmd_go_i && !enable_i) |=> state_q == S_IDLE);

    assert_words_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> words_q == '0);

    assert_tmo_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL && ev_set[BIT_TMO]) |-> !ev_set[BIT_DONE]);

    assert_eval_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EVAL) |=> state_q == S_IDLE);

endmodule

// File: tb/test_cmd_status_unit.sv
module test_cmd_status_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         cmd_go = 1'b0;
    logic [15:0]  cmd_word = '0;
    logic [127:0] rsp_bytes = '0;
    logic [4:0]   rsp_len = '0;
    logic         card_det = 1'b0;
    logic         reg_wr = 1'b0;
    logic         reg_sel = 1'b0;
    logic [15:0]  reg_wdata = '0;
    logic         irq;
    logic [15:0]  status, ien;
    logic [127:0] words;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] bt [16];

    always #2.5 clk = ~clk;

    cmd_status_unit i_cmd_status_unit (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .cmd_go_i(cmd_go),
        .cmd_word_i(cmd_word), .rsp_bytes_i(rsp_bytes), .rsp_len_i(rsp_len),
        .card_det_i(card_det), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .irq_o(irq), .status_o(status),
        .ien_o(ien), .rsp_words_o(words)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pack_bytes();
        for (int j = 0; j < 16; j++) rsp_bytes[8*j +: 8] = bt[j];
    endtask

    // strobe at one falling edge; returns at the falling edge after the second rising edge
    task automatic issue(input logic [15:0] w, input logic [4:0] len);
        @(negedge clk);
        cmd_go = 1'b1; cmd_word = w; rsp_len = len;
        @(negedge clk);
        cmd_go = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [15:0] mkcmd(input int idx, input bit init, input int typ, input bit busy);
        return {4'b0000, busy, 3'(typ), init, 1'b0, 6'(idx)};
    endfunction

    function automatic int need(input int typ);
        if (typ == 2) return 16;
        if (typ == 1 || typ == 3 || typ == 6) return 4;
        return 0;
    endfunction

    function automatic logic [127:0] exp_words();
        logic [127:0] v;
        for (int k = 0; k < 8; k++) v[16*k +: 16] = {bt[2*(7-k)], bt[2*(7-k)+1]};
        return v;
    endfunction

    task automatic fill(input bit e, input int idx, input int typ);
        bt[0] = e ? 8'h80 : 8'h00;
        bt[1] = 8'h00;
        bt[2] = e ? 8'h85 : 8'h05;
        bt[3] = 8'h21;
        for (int j = 4; j < 16; j++) bt[j] = 8'((j * 29 + idx * 3 + typ) & 255);
        pack_bytes();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset status R6", 128'(status), 0);
        chk("reset enable R7", 128'(ien), 0);
        chk("reset irq R7", 128'(irq), 0);
        chk("reset words R9", words, 0);
        enable = 1'b1;

        // sweep: R2 R3 R4 R5 R9
        for (int typ = 0; typ < 8; typ++)
        for (int li = 0; li < 5; li++)
        for (int ii = 0; ii < 3; ii++)
        for (int init = 0; init < 2; init++)
        for (int e = 0; e < 2; e++) begin
            int len, idx, nd;
            logic [15:0] es;
            logic [31:0] cs32;
            logic [15:0] cs16;
            bit ld;
            len = (li == 0) ? 0 : (li == 1) ? 3 : (li == 2) ? 4 : (li == 3) ? 15 : 16;
            idx = (ii == 0) ? 0 : (ii == 1) ? 12 : 5;
            fill(e[0], idx, typ);
            reg_write(1'b0, 16'hFFFF);
            issue(mkcmd(idx, init[0], typ, ii[0]), 5'(len));
            nd = need(typ);
            cs32 = {bt[0], bt[1], bt[2], bt[3]};
            cs16 = {bt[2], bt[3]};
            ld = 1'b0;
            if (init != 0 && idx == 0) es = 16'h0001;
            else if (len < nd) es = 16'h0080;
            else begin
                es = (idx == 12) ? 16'h0005 : 16'h0001;
                if (typ == 1 && (cs32 & 32'hFDF90000) != 0) es |= 16'h4000;
                if (typ == 6 && (cs16 & 16'hE008) != 0) es |= 16'h4000;
                ld = (nd != 0);
            end
            chk($sformatf("R3/R4/R5/R2 status typ%0d len%0d idx%0d init%0d", typ, len, idx, init),
                128'(status), 128'(es));
            chk($sformatf("R9 words typ%0d len%0d idx%0d init%0d", typ, len, idx, init),
                words, ld ? exp_words() : 128'd0);
        end

        // R5: a clean response clears a standing error bit
        fill(1'b1, 5, 1);
        reg_write(1'b0, 16'hFFFF);
        issue(mkcmd(5, 0, 1, 0), 5'd4);
        chk("R5 error set", 128'(status), 128'h4001);
        fill(1'b0, 5, 1);
        issue(mkcmd(5, 0, 1, 0), 5'd4);
        chk("R5 error cleared", 128'(status), 128'h0001);

        // R1: dropped while disabled, words and status untouched
        fill(1'b0, 9, 2);
        reg_write(1'b0, 16'hFFFF);
        issue(mkcmd(9, 0, 2, 0), 5'd16);
        reg_write(1'b0, 16'hFFFF);
        enable = 1'b0;
        issue(mkcmd(9, 0, 2, 0), 5'd0);
        chk("R1 disabled status", 128'(status), 0);
        chk("R1 disabled words", words, exp_words());
        enable = 1'b1;

        // R6: partial clear
        issue(mkcmd(12, 0, 0, 0), 5'd0);
        reg_write(1'b0, 16'h0001);
        chk("R6 partial w1c", 128'(status), 128'h0004);

        // R8 and R6: card-detect rise with a same-cycle clear of that bit
        reg_write(1'b0, 16'hFFFF);
        @(negedge clk);
        card_det = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0002;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R6 set wins / R8 rise", 128'(status), 128'h0002);
        reg_write(1'b0, 16'h0002);
        repeat (3) @(negedge clk);
        chk("R8 steady high no set", 128'(status), 0);
        card_det = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 fall no set", 128'(status), 0);
        card_det = 1'b1;
        @(negedge clk);
        chk("R8 second rise", 128'(status), 128'h0002);
        reg_write(1'b0, 16'hFFFF);

        // R7: enable width and registered interrupt
        reg_write(1'b1, 16'hFFFF);
        chk("R7 enable 15 bits", 128'(ien), 128'h7FFF);
        reg_write(1'b1, 16'h0080);
        @(negedge clk);
        chk("R7 irq idle", 128'(irq), 0);
        issue(mkcmd(3, 0, 2, 0), 5'd0);
        chk("R7 timeout status", 128'(status), 128'h0080);
        chk("R7 irq not yet", 128'(irq), 0);
        @(negedge clk);
        chk("R7 irq raised", 128'(irq), 1);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0080;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R7 irq held one cycle", 128'(irq), 1);
        @(negedge clk);
        chk("R7 irq dropped", 128'(irq), 0);
        reg_write(1'b1, 16'h0001);
        issue(mkcmd(3, 0, 2, 0), 5'd0);
        repeat (2) @(negedge clk);
        chk("R7 masked irq", 128'(irq), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule